// File: doc/BRIEF.md
# Message-Interrupt Vector Table Page

This block holds the per-vector interrupt message state of a device function in one 4 KiB register page. The lower half of the page is an array of 16-byte vector entries. Each entry holds a 64-bit message address, a 32-bit message payload and a control word whose bit 0 masks that vector. The upper half, starting at page offset 0x800, holds the pending bits as a packed bit array. Host software reaches the page through a simple memory-mapped slave port that honours only 32-bit accesses.

The interrupt dispatcher next to this block uses side ports. It looks up the address and payload of any vector without disturbing the host port. It reads the effective mask of every vector, which combines the entry mask with a function-wide mask input. It sets and clears pending bits. Whenever the host writes a word of an entry, the block reports the vector it touched one cycle later. The dispatcher can then re-evaluate that vector, for example to deliver a pending message once the vector is unmasked. Message generation is not part of this block.

Top module: `msix_vector_page`

## Requirements
- R1: A 32-bit write at offset 16*v + 4*k (k = 0 address low, 1 address high, 2 payload, 3 control) to an implemented vector v stores all 32 bits. A 32-bit read returns the stored word on `mmio_rdata` with `mmio_rvalid` high exactly one cycle after the request. `mmio_rvalid` is low in every cycle that does not follow a read request.
- R2: The page offset is the address with bits 1:0 forced to zero. The vector index is that offset divided by 16. Any low-bit pattern reaches the same word.
- R3: After reset every entry word is zero, except that bit 0 of every control word is one. Every pending bit is zero, and `wr_evt` and `mmio_rvalid` are low.
- R4: An access with `mmio_size` other than 2 (0 = byte, 1 = halfword, 3 = reserved) changes no state. For a read of that kind, `mmio_rvalid` still pulses and the data is zero.
- R5: `vec_masked[v]` is high when bit 0 of vector v's control word is one or when `func_mask` is high.
- R6: The pending bit of vector v reads at bit (v mod 8) of byte 0x800 + v/8. Seen as little-endian 32-bit words, it is bit (v mod 32) of the word at 0x800 + 4*(v/32). Host writes to this array have no effect.
- R7: `pend_set[v]` sets and `pend_clr[v]` clears the pending bit of v at the next clock edge. When both are high, set wins. `pend_bits` shows the array, and the bits hold when neither input is high.
- R8: Offsets in the lower half beyond the last implemented entry, and offsets in the upper half beyond the last pending word, read as zero and ignore writes.
- R9: One cycle after an honoured entry write, `wr_evt` is high for one cycle and `wr_evt_vec` gives the vector. Illegal-size writes, pending-array writes and unimplemented-offset writes raise no event.
- R10: `lk_addr` is {address high, address low} and `lk_data` is the payload of vector `lk_vec`, combinationally. Both are zero when `lk_vec` is not below the vector count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_req | input | 1 | Host access request, one cycle per access |
| mmio_we | input | 1 | 1 = write, 0 = read |
| mmio_size | input | 2 | Access size: 0 byte, 1 halfword, 2 dword, 3 reserved |
| mmio_addr | input | 12 | Page byte offset |
| mmio_wdata | input | 32 | Write data |
| mmio_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mmio_rdata | output | 32 | Read data |
| func_mask | input | 1 | Function-wide mask |
| lk_vec | input | VEC_W+1 | Vector to look up |
| lk_addr | output | 64 | Message address of the looked-up vector |
| lk_data | output | 32 | Message payload of the looked-up vector |
| vec_masked | output | NUM_VEC | Effective mask of each vector |
| pend_set | input | NUM_VEC | Set pending bits |
| pend_clr | input | NUM_VEC | Clear pending bits |
| pend_bits | output | NUM_VEC | Pending array |
| wr_evt | output | 1 | An entry was written in the previous cycle |
| wr_evt_vec | output | VEC_W | Vector of that write |

## Verification
The bench targets these corner cases:

- **Narrow accesses to live entries.** A design that honoured them would corrupt words that a later 32-bit read-back exposes.
- **Unaligned low address bits.** A design that kept them would hit the wrong word.
- **Offsets just beyond the last entry and beyond the first pending word.** A design with loose decoding would alias them onto entry 0 or onto the pending word.
- **Host writes to the pending array.** A design that accepted them would show the stray bits on `pend_bits`.
- **Simultaneous set and clear.** A design with the wrong priority would drop a pending bit.
- **Reset after a loaded table.** A design that reset the control word to zero would leave vectors unmasked.

// File: rtl/msixtbl_pkg.sv
package msixtbl_pkg;
  localparam int PAGE_AW     = 12;
  localparam int DW          = 32;
  localparam int ENTRY_WORDS = 4;
  localparam int MAX_VEC     = 128;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_ENTRY = 2'd1,
    RGN_PBA   = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } entry_word_e;

  typedef logic [ENTRY_WORDS-1:0][DW-1:0] entry_t;

  // reset image of one entry: only the control mask bit is set
  localparam entry_t ENTRY_RST = entry_t'({32'd1, 32'd0, 32'd0, 32'd0});

  // dword address is the page offset with the two byte bits dropped
  function automatic logic in_pba(input logic [9:0] dwa);
    return dwa[9];
  endfunction

  function automatic logic [6:0] entry_of(input logic [9:0] dwa);
    return dwa[8:2];
  endfunction

  function automatic logic [1:0] word_of(input logic [9:0] dwa);
    return dwa[1:0];
  endfunction

  function automatic logic [8:0] pba_word_of(input logic [9:0] dwa);
    return dwa[8:0];
  endfunction

  function automatic int pba_words(input int nvec);
    return (nvec + DW - 1) / DW;
  endfunction
endpackage

// File: rtl/msixtbl_decode.sv
module msixtbl_decode
  import msixtbl_pkg::*;
#(
  parameter int NUM_VEC = 32,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int PBA_DW = pba_words(NUM_VEC),
  localparam int PBA_IW = (PBA_DW > 1) ? $clog2(PBA_DW) : 1
) (
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [9:0]        dw_addr,
  output region_e           rgn,
  output logic [VEC_W-1:0]  vec_idx,
  output logic [1:0]        word_sel,
  output logic [PBA_IW-1:0] pba_idx,
  output logic              rd_ok,
  output logic              wr_entry
);
  localparam logic [7:0] NV8     = 8'(NUM_VEC);
  localparam logic [9:0] PBA_D10 = 10'(PBA_DW);

  logic [6:0] ent_full;
  logic [8:0] pba_full;
  logic       is_dword;

  always_comb begin
    ent_full = entry_of(dw_addr);
    pba_full = pba_word_of(dw_addr);
    word_sel = word_of(dw_addr);
    if (in_pba(dw_addr)) begin
      rgn = ({1'b0, pba_full} < PBA_D10) ? RGN_PBA : RGN_NONE;
    end else begin
      rgn = ({1'b0, ent_full} < NV8) ? RGN_ENTRY : RGN_NONE;
    end
  end

  assign vec_idx  = ent_full[VEC_W-1:0];
  assign pba_idx  = pba_full[PBA_IW-1:0];
  assign is_dword = (size == SZ_DWORD);
  assign rd_ok    = req && !we && is_dword;
  assign wr_entry = req && we && is_dword && (rgn == RGN_ENTRY);
endmodule

// File: rtl/msixtbl_entry.sv
module msixtbl_entry
  import msixtbl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    word_sel,
  input  logic [DW-1:0] wdata,
  output entry_t        words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= ENTRY_RST;
    end else if (wr_en) begin
      words[word_sel] <= wdata;
    end
  end
endmodule

// File: rtl/msixtbl_pba.sv
module msixtbl_pba #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] bits_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_o[v] <= 1'b0;
      end else if (set_i[v]) begin
        bits_o[v] <= 1'b1;
      end else if (clr_i[v]) begin
        bits_o[v] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msix_vector_page.sv
module msix_vector_page
  import msixtbl_pkg::*;
#(
  parameter int NUM_VEC = 32,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mmio_req,
  input  logic               mmio_we,
  input  logic [1:0]         mmio_size,
  input  logic [11:0]        mmio_addr,
  input  logic [31:0]        mmio_wdata,
  output logic               mmio_rvalid,
  output logic [31:0]        mmio_rdata,
  input  logic               func_mask,
  input  logic [VEC_W:0]     lk_vec,
  output logic [63:0]        lk_addr,
  output logic [31:0]        lk_data,
  output logic [NUM_VEC-1:0] vec_masked,
  input  logic [NUM_VEC-1:0] pend_set,
  input  logic [NUM_VEC-1:0] pend_clr,
  output logic [NUM_VEC-1:0] pend_bits,
  output logic               wr_evt,
  output logic [VEC_W-1:0]   wr_evt_vec
);
  localparam int PBA_DW = pba_words(NUM_VEC);
  localparam int PBA_IW = (PBA_DW > 1) ? $clog2(PBA_DW) : 1;
  localparam logic [VEC_W:0] NV_L = (VEC_W+1)'(NUM_VEC);

  // named internal events, also observed by the checker
  region_e           rgn;
  logic [VEC_W-1:0]  vec_idx;
  logic [1:0]        word_sel;
  logic [PBA_IW-1:0] pba_idx;
  logic              rd_ok;
  logic              wr_entry;

  entry_t ent [NUM_VEC];
  logic [PBA_DW*DW-1:0] pend_pad;
  logic [DW-1:0]        rd_mux;

  msixtbl_decode #(.NUM_VEC(NUM_VEC)) u_dec (
    .req      (mmio_req),
    .we       (mmio_we),
    .size     (mmio_size),
    .dw_addr  (mmio_addr[11:2]),
    .rgn      (rgn),
    .vec_idx  (vec_idx),
    .word_sel (word_sel),
    .pba_idx  (pba_idx),
    .rd_ok    (rd_ok),
    .wr_entry (wr_entry)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    logic hit;
    assign hit = wr_entry && (vec_idx == VEC_W'(g));
    msixtbl_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit),
      .word_sel (word_sel),
      .wdata    (mmio_wdata),
      .words    (ent[g])
    );
    assign vec_masked[g] = ent[g][W_CTRL][0] | func_mask;
  end

  msixtbl_pba #(.NUM_VEC(NUM_VEC)) u_pba (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pend_set),
    .clr_i  (pend_clr),
    .bits_o (pend_bits)
  );

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend_bits;
  end

  always_comb begin
    unique case (rgn)
      RGN_ENTRY: rd_mux = ent[vec_idx][word_sel];
      RGN_PBA:   rd_mux = pend_pad[pba_idx*DW +: DW];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_rvalid <= 1'b0;
      mmio_rdata  <= '0;
    end else begin
      mmio_rvalid <= mmio_req && !mmio_we;
      mmio_rdata  <= rd_ok ? rd_mux : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_evt     <= 1'b0;
      wr_evt_vec <= '0;
    end else begin
      wr_evt <= wr_entry;
      if (wr_entry) wr_evt_vec <= vec_idx;
    end
  end

  always_comb begin
    if (lk_vec < NV_L) begin
      lk_addr = {ent[lk_vec[VEC_W-1:0]][W_ADDR_HI], ent[lk_vec[VEC_W-1:0]][W_ADDR_LO]};
      lk_data = ent[lk_vec[VEC_W-1:0]][W_DATA];
    end else begin
      lk_addr = '0;
      lk_data = '0;
    end
  end
endmodule

// File: rtl/msixtbl_checker.sv
module msixtbl_checker #(
  parameter int NUM_VEC = 32,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mmio_req,
  input logic               mmio_we,
  input logic [1:0]         mmio_size,
  input logic [11:0]        mmio_addr,
  input logic               mmio_rvalid,
  input logic [31:0]        mmio_rdata,
  input logic               func_mask,
  input logic [NUM_VEC-1:0] vec_masked,
  input logic [NUM_VEC-1:0] pend_set,
  input logic [NUM_VEC-1:0] pend_clr,
  input logic [NUM_VEC-1:0] pend_bits,
  input logic               wr_entry,
  input logic               wr_evt,
  input logic [VEC_W-1:0]   wr_evt_vec
);
  localparam logic [12:0] ENT_END = 13'(NUM_VEC * 16);

  // R9: a legal write inside the table raises the event for that vector
  p_evt_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req && mmio_we && mmio_size == 2'd2 && ({1'b0, mmio_addr} < ENT_END))
    |=> (wr_evt && wr_evt_vec == $past(mmio_addr[VEC_W+3:4])));

  // R9: no event unless the decoder accepted an entry write
  p_evt_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_entry |=> !wr_evt);

  // R4: narrow reads answer with zero data
  p_narrow_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req && !mmio_we && mmio_size != 2'd2) |=> (mmio_rvalid && mmio_rdata == 32'd0));

  // R1: read valid follows every read request and nothing else
  p_rvalid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req && !mmio_we) |=> mmio_rvalid);
  p_rvalid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmio_req && !mmio_we) |=> !mmio_rvalid);

  // R7: pending bits move only through the side port; set wins
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set == '0 && pend_clr == '0) |=> $stable(pend_bits));
  p_pend_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set != '0) |=> ((pend_bits & $past(pend_set)) == $past(pend_set)));

  // R5: function mask masks every vector
  p_func_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    func_mask |-> (&vec_masked));
endmodule

bind msix_vector_page msixtbl_checker #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mmio_req    (mmio_req),
  .mmio_we     (mmio_we),
  .mmio_size   (mmio_size),
  .mmio_addr   (mmio_addr),
  .mmio_rvalid (mmio_rvalid),
  .mmio_rdata  (mmio_rdata),
  .func_mask   (func_mask),
  .vec_masked  (vec_masked),
  .pend_set    (pend_set),
  .pend_clr    (pend_clr),
  .pend_bits   (pend_bits),
  .wr_entry    (wr_entry),
  .wr_evt      (wr_evt),
  .wr_evt_vec  (wr_evt_vec)
);

// File: tb/msix_vector_page_bench.sv
module msix_vector_page_bench;
  localparam int NV = 32;
  localparam int VW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mmio_req = 1'b0, mmio_we = 1'b0;
  logic [1:0]    mmio_size = 2'd2;
  logic [11:0]   mmio_addr = '0;
  logic [31:0]   mmio_wdata = '0;
  logic          mmio_rvalid;
  logic [31:0]   mmio_rdata;
  logic          func_mask = 1'b0;
  logic [VW:0]   lk_vec = '0;
  logic [63:0]   lk_addr;
  logic [31:0]   lk_data;
  logic [NV-1:0] vec_masked, pend_bits;
  logic [NV-1:0] pend_set = '0, pend_clr = '0;
  logic          wr_evt;
  logic [VW-1:0] wr_evt_vec;

  msix_vector_page #(.NUM_VEC(NV)) u_msix_vector_page (.*);

  always #4 clk = ~clk;

  // behavioural reference
  logic [31:0]   m_tbl [NV][4];
  logic [NV-1:0] m_pend;
  logic          e_rvalid, e_evt;
  logic [31:0]   e_rdata;
  int            e_evt_vec;
  string         e_rtag, ent_tag;
  int            n_chk = 0, n_fail = 0, cycles = 0;
  logic          checking = 1'b0;

  always @(posedge clk) begin
    int o;
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        for (int w = 0; w < 4; w++) m_tbl[v][w] = (w == 3) ? 32'd1 : 32'd0;
      end
      m_pend = '0; e_rvalid = 0; e_rdata = 0; e_evt = 0; e_evt_vec = 0; e_rtag = "R3";
    end else begin
      o = int'(mmio_addr) & 'hFFC;
      e_rvalid = mmio_req && !mmio_we;
      e_rdata = 0;
      e_rtag = "R1";
      if (mmio_req && !mmio_we) begin
        if (mmio_size != 2'd2) e_rtag = "R4";
        else if (o < 'h800) begin
          if (o / 16 < NV) begin e_rdata = m_tbl[o/16][(o%16)/4]; e_rtag = ent_tag; end
          else e_rtag = "R8";
        end else begin
          if (o - 'h800 < 4) begin e_rdata = m_pend; e_rtag = "R6"; end
          else e_rtag = "R8";
        end
      end
      e_evt = 0;
      if (mmio_req && mmio_we && mmio_size == 2'd2 && o < 'h800 && o / 16 < NV) begin
        m_tbl[o/16][(o%16)/4] = mmio_wdata;
        e_evt = 1;
        e_evt_vec = o / 16;
      end
      m_pend = (m_pend & ~pend_clr) | pend_set;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      logic [NV-1:0] em;
      chk(e_rtag, 64'(mmio_rvalid), 64'(e_rvalid));
      chk(e_rtag, 64'(mmio_rdata), 64'(e_rdata));
      chk("R9 wr_evt", 64'(wr_evt), 64'(e_evt));
      if (e_evt) chk("R9 wr_evt_vec", 64'(wr_evt_vec), 64'(e_evt_vec));
      chk("R7 pend_bits", 64'(pend_bits), 64'(m_pend));
      for (int v = 0; v < NV; v++) em[v] = m_tbl[v][3][0] | func_mask;
      chk("R5 vec_masked", 64'(vec_masked), 64'(em));
      if (int'(lk_vec) < NV) begin
        chk("R10 lk_addr", lk_addr, {m_tbl[lk_vec][1], m_tbl[lk_vec][0]});
        chk("R10 lk_data", 64'(lk_data), 64'(m_tbl[lk_vec][2]));
      end else begin
        chk("R10 lk_addr range", lk_addr, 64'd0);
        chk("R10 lk_data range", 64'(lk_data), 64'd0);
      end
    end
  end

  task automatic cyc(input logic req, input logic we, input logic [1:0] sz,
                     input logic [11:0] a, input logic [31:0] d,
                     input logic [NV-1:0] ps, input logic [NV-1:0] pc);
    @(negedge clk); #1;
    mmio_req = req; mmio_we = we; mmio_size = sz; mmio_addr = a; mmio_wdata = d;
    pend_set = ps; pend_clr = pc;
    lk_vec = lk_vec + 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz = 2'd2);
    cyc(1, 0, sz, a, 32'd0, '0, '0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    cyc(1, 1, sz, a, d, '0, '0);
  endtask

  task automatic idle();
    cyc(0, 0, 2'd2, 12'd0, 32'd0, '0, '0);
  endtask

  task automatic sweep(input string tag);
    ent_tag = tag;
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 4; w++) rd(12'(v * 16 + w * 4));
    end
    rd(12'h800);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    mmio_req = 0; pend_set = '0; pend_clr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    ent_tag = "R3";
    do_reset();
    checking = 1'b1;
    // R3: reset image of the whole page
    chk("R3 masks after reset", 64'(vec_masked), 64'({NV{1'b1}}));
    chk("R3 pending after reset", 64'(pend_bits), 64'd0);
    sweep("R3");

    // R1: load every word of every entry, then read back
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 4; w++)
        wr(12'(v * 16 + w * 4), 32'hA500_0000 ^ 32'(v << 8) ^ 32'(w) ^ ((w == 3) ? 32'(v & 1) : 32'h0));
    end
    sweep("R1");

    // R2: low address bits are ignored
    wr(12'h052, 32'h1234_5678);
    wr(12'h0A7, 32'hCAFE_F00D);
    wr(12'h1F1, 32'h0BAD_BEEF);
    ent_tag = "R2";
    rd(12'h053); rd(12'h0A5); rd(12'h1F3); rd(12'h050);
    idle();

    // R4: narrow accesses change nothing and read zero
    wr(12'h030, 32'hFFFF_FFFF, 2'd0);
    wr(12'h030, 32'hFFFF_FFFF, 2'd1);
    wr(12'h03C, 32'h0000_0000, 2'd3);
    rd(12'h030, 2'd0); rd(12'h034, 2'd1); rd(12'h03C, 2'd3);
    ent_tag = "R4";
    rd(12'h030); rd(12'h03C);
    idle();

    // R5: function mask and per-vector mask
    for (int v = 0; v < NV; v++) wr(12'(v * 16 + 12), 32'h0);
    idle();
    func_mask = 1'b1; idle(); idle();
    func_mask = 1'b0; idle();
    wr(12'h07C, 32'h1); idle();
    wr(12'h07C, 32'hFFFF_FFFE); idle();

    // R6, R7: pending array through side port, read-only from host
    cyc(0, 0, 2'd2, 12'd0, 32'd0, 32'h8000_0001, '0); rd(12'h800);
    cyc(0, 0, 2'd2, 12'd0, 32'd0, 32'h0001_0100, 32'h0000_0001); rd(12'h800);
    cyc(0, 0, 2'd2, 12'd0, 32'd0, 32'h0000_0200, 32'h0000_0200); rd(12'h802);
    cyc(0, 0, 2'd2, 12'd0, 32'd0, '0, 32'h8000_0100); rd(12'h800);
    wr(12'h800, 32'hFFFF_FFFF); rd(12'h800);
    wr(12'h800, 32'h0000_0000); rd(12'h800);
    cyc(1, 0, 2'd2, 12'h800, 32'd0, 32'h0000_0040, '0); rd(12'h800);
    idle();

    // R8: unimplemented offsets
    wr(12'h200, 32'hDEAD_0001); wr(12'h7FC, 32'hDEAD_0002);
    wr(12'h804, 32'hDEAD_0003); wr(12'hFFC, 32'hDEAD_0004);
    rd(12'h200); rd(12'h7FC); rd(12'h804); rd(12'hFFC); rd(12'h5F0);
    sweep("R8");

    // R10: out-of-range lookup indices are covered as lk_vec wraps
    for (int i = 0; i < 70; i++) idle();

    // R3: reset after a loaded table
    do_reset();
    chk("R3 masks after second reset", 64'(vec_masked), 64'({NV{1'b1}}));
    sweep("R3");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule